// File: doc/BRIEF.md
# Serial Bit-Stream Modulo Reducer

This block finds the remainder of an unsigned dividend divided by a small constant `N`. It does not hold the whole operand. It takes the dividend one bit per accepted cycle, starting with the most significant bit, and keeps a running residue in a register that has exactly one encoding for each value from 0 to N-1. Each accepted bit moves the residue through a transition table, so the block contains no divider and no subtractor chain.

The next-residue table is computed during elaboration from the parameter `N`. Each of the N residue states has two successors, one for each input bit value.

A producer starts a dividend with a clear strobe and then presents bits with a valid strobe. It marks the final bit with a last flag. The clear strobe may share a cycle with the first bit. One cycle after the last bit is accepted, the block raises a single-cycle completion pulse. At the same time the result port loads the remainder, and it keeps that value until the next completion.

Top module: `serial_mod_reducer`

## Requirements
- R1: When `start_i` is high and `bit_vld_i` is low, `residue_o` is 0 after the next rising clock edge.
- R2: While reset is active and on the first cycle after it, `residue_o`, `rem_o` and `done_o` are all 0.
- R3: `residue_o` is an unsigned binary value of width clog2(N) and always lies in the range 0 to N-1.
- R4: When `bit_vld_i` is high and `start_i` is low, the residue becomes (2*m + `bit_i`) mod N, where m is the current residue. After the bits of a dividend have been fed MSB first, `residue_o` equals that bit prefix mod N.
- R5: A cycle with both `bit_vld_i` and `start_i` low leaves `residue_o` unchanged. `bit_i` and `last_i` have no effect in such a cycle, and `done_o` stays low.
- R6: When `bit_vld_i` and `last_i` are both high, `done_o` is high for exactly the following cycle. In that cycle `rem_o` holds the residue that includes the last bit.
- R7: `rem_o` changes only in the cycle after an accepted last bit. At all other times it holds its value.
- R8: When `start_i` and `bit_vld_i` are high in the same cycle, that bit is the first (most significant) bit of a new dividend. The residue becomes `bit_i`, whatever its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the residue to begin a new dividend |
| bit_vld_i | input | 1 | Marks `bit_i` as an accepted dividend bit |
| bit_i | input | 1 | Dividend bit, most significant first |
| last_i | input | 1 | Marks the accepted bit as the final one |
| residue_o | output | clog2(N) | Running residue |
| rem_o | output | clog2(N) | Remainder latched at completion |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that every input is a known level and changes only between clock edges. They also assume that `bit_i` and `last_i` carry meaning only while `bit_vld_i` is high, so the checks never read them in other cycles.

The stimulus drives all inputs at the falling edge. It puts random values on `bit_i` and `last_i` during idle gaps to show that those values are ignored. Dividends are no wider than 64 bits, so the bench can compute the expected remainders with native arithmetic. The stimulus also covers the orderings the checks depend on: back-to-back one-bit dividends, a clear strobe merged with the first bit, and a dividend abandoned partway through.

// File: rtl/mr_pkg.sv
package mr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_CLEAR   = 2'd1,
        ACT_STEP    = 2'd2,
        ACT_RESTART = 2'd3
    } mr_act_e;

    function automatic mr_act_e mr_decode(input logic start, input logic vld);
        mr_act_e act;
        unique case ({start, vld})
            2'b00:   act = ACT_HOLD;
            2'b10:   act = ACT_CLEAR;
            2'b01:   act = ACT_STEP;
            default: act = ACT_RESTART;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/mr_step_table.sv
module mr_step_table #(
    parameter int unsigned N  = 11,
    parameter int unsigned RW = (N < 2) ? 1 : $clog2(N)
) (
    input  logic [RW-1:0] cur_i,
    input  logic          bit_i,
    output logic [RW-1:0] nxt_o
);

    generate
        if (N < 2) begin : g_bad_modulus
            $error("mr_step_table: modulus N must be at least 2");
        end
    endgenerate

    logic [RW-1:0] succ_zero [N];
    logic [RW-1:0] succ_one  [N];

    for (genvar s = 0; s < int'(N); s++) begin : g_state
        localparam logic [RW-1:0] ON_ZERO = RW'((2 * s) % N);
        localparam logic [RW-1:0] ON_ONE  = RW'((2 * s + 1) % N);
        assign succ_zero[s] = ON_ZERO;
        assign succ_one[s]  = ON_ONE;
    end

    always_comb begin
        nxt_o = '0;
        for (int s = 0; s < int'(N); s++) begin
            if (cur_i == RW'(s)) begin
                nxt_o = bit_i ? succ_one[s] : succ_zero[s];
            end
        end
    end

endmodule

// File: rtl/mr_residue_reg.sv
module mr_residue_reg
    import mr_pkg::*;
#(
    parameter int unsigned N  = 11,
    parameter int unsigned RW = (N < 2) ? 1 : $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          vld_i,
    input  logic          bit_i,
    output logic [RW-1:0] res_o,
    output logic [RW-1:0] res_nxt_o
);

    typedef struct packed {
        logic [RW-1:0] res;
    } res_state_t;

    res_state_t    st_d, st_q;
    mr_act_e       act;
    logic [RW-1:0] tbl_cur;
    logic [RW-1:0] tbl_nxt;

    assign act     = mr_decode(start_i, vld_i);
    assign tbl_cur = (act == ACT_RESTART) ? '0 : st_q.res;

    mr_step_table #(.N(N), .RW(RW)) u_table (
        .cur_i (tbl_cur),
        .bit_i (bit_i),
        .nxt_o (tbl_nxt)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_HOLD:    st_d.res = st_q.res;
            ACT_CLEAR:   st_d.res = '0;
            ACT_STEP:    st_d.res = tbl_nxt;
            ACT_RESTART: st_d.res = tbl_nxt;
            default:     st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o     = st_q.res;
    assign res_nxt_o = st_d.res;

endmodule

// File: rtl/mr_result_latch.sv
module mr_result_latch #(
    parameter int unsigned RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [RW-1:0] val_i,
    output logic [RW-1:0] rem_o,
    output logic          done_o
);

    typedef struct packed {
        logic [RW-1:0] rem;
        logic          done;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.done = fire_i;
        if (fire_i) out_d.rem = val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rem_o  = out_q.rem;
    assign done_o = out_q.done;

endmodule

// File: rtl/serial_mod_reducer.sv
module serial_mod_reducer #(
    parameter int unsigned N  = 11,
    localparam int unsigned RW = (N < 2) ? 1 : $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          bit_vld_i,
    input  logic          bit_i,
    input  logic          last_i,
    output logic [RW-1:0] residue_o,
    output logic [RW-1:0] rem_o,
    output logic          done_o
);

    logic [RW-1:0] res_nxt;
    logic          fire;

    assign fire = bit_vld_i & last_i;

    mr_residue_reg #(.N(N), .RW(RW)) u_residue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .vld_i     (bit_vld_i),
        .bit_i     (bit_i),
        .res_o     (residue_o),
        .res_nxt_o (res_nxt)
    );

    mr_result_latch #(.RW(RW)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .val_i  (res_nxt),
        .rem_o  (rem_o),
        .done_o (done_o)
    );

endmodule

// File: rtl/mr_checker.sv
module mr_checker #(
    parameter int unsigned N  = 11,
    parameter int unsigned RW = (N < 2) ? 1 : $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          bit_vld_i,
    input logic          bit_i,
    input logic          last_i,
    input logic [RW-1:0] residue_o,
    input logic [RW-1:0] rem_o,
    input logic          done_o
);

    AST_RES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(residue_o) < int'(N)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) start_i && !bit_vld_i |=> residue_o == '0); // R1

    AST_STEP_RULE: assert property (@(posedge clk) disable iff (!rst_n) bit_vld_i && !start_i |=> int'(residue_o) == (2 * int'($past(residue_o)) + int'($past(bit_i))) % int'(N)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bit_vld_i && !start_i |=> $stable(residue_o) && !done_o); // R5

    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) bit_vld_i && last_i |=> done_o && rem_o == residue_o); // R6

    AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(bit_vld_i && last_i) |=> $stable(rem_o) && !done_o); // R7

    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n) start_i && bit_vld_i |=> int'(residue_o) == int'($past(bit_i))); // R8

endmodule

bind serial_mod_reducer mr_checker #(.N(N)) u_mr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .last_i    (last_i),
    .residue_o (residue_o),
    .rem_o     (rem_o),
    .done_o    (done_o)
);

// File: tb/tb_serial_mod_reducer.sv
module tb_serial_mod_reducer;

    localparam int unsigned N      = 11;
    localparam int unsigned RW     = $clog2(N);
    localparam time         CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          bit_vld_i = 1'b0;
    logic          bit_i = 1'b0;
    logic          last_i = 1'b0;
    logic [RW-1:0] residue_o;
    logic [RW-1:0] rem_o;
    logic          done_o;

    int n_chk = 0;
    int n_err = 0;
    int exp_res = 0;
    int exp_rem = 0;
    bit ended = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    serial_mod_reducer #(.N(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .bit_vld_i (bit_vld_i),
        .bit_i     (bit_i),
        .last_i    (last_i),
        .residue_o (residue_o),
        .rem_o     (rem_o),
        .done_o    (done_o)
    );

    function automatic int ref_mod(longint unsigned v);
        return int'(v % longint'(N));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(logic s, logic v, logic b, logic l);
        start_i = s; bit_vld_i = v; bit_i = b; last_i = l;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_gap();
        cyc(1'b0, 1'b0, 1'($urandom % 2), 1'($urandom % 2));
        chk("R5 idle residue", int'(residue_o), exp_res);
        chk("R5 idle done", int'(done_o), 0);
        chk("R7 rem hold", int'(rem_o), exp_rem);
    endtask

    task automatic send(longint unsigned val, int nbits, bit merged, bit gaps);
        if (!merged) begin
            cyc(1'b1, 1'b0, 1'($urandom % 2), 1'($urandom % 2));
            exp_res = 0;
            chk("R1 clear", int'(residue_o), 0);
            chk("R7 rem hold on clear", int'(rem_o), exp_rem);
        end
        for (int i = nbits - 1; i >= 0; i--) begin
            bit first;
            first = (i == nbits - 1);
            if (gaps) while ($urandom % 4 == 0) idle_gap();
            cyc(merged && first, 1'b1, val[i], i == 0);
            exp_res = ref_mod(val >> i);
            if (merged && first) chk("R8 merged first bit", int'(residue_o), int'(val[i]));
            else                 chk("R4 step", int'(residue_o), exp_res);
            chk("R3 range", int'(int'(residue_o) < int'(N)), 1);
            if (i == 0) begin
                exp_rem = ref_mod(val);
                chk("R6 done", int'(done_o), 1);
                chk("R6 remainder", int'(rem_o), exp_rem);
            end else begin
                chk("R6 no early done", int'(done_o), 0);
                chk("R7 rem hold", int'(rem_o), exp_rem);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        longint unsigned v;
        int nb;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        chk("R2 reset residue", int'(residue_o), 0);
        chk("R2 reset rem", int'(rem_o), 0);
        chk("R2 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 post-reset residue", int'(residue_o), 0);
        chk("R2 post-reset done", int'(done_o), 0);

        // directed corner cases
        send(64'd0, 1, 1'b0, 1'b0);
        send(64'd1, 1, 1'b1, 1'b0);
        send(64'd0, 1, 1'b1, 1'b0);
        send(64'd1, 1, 1'b1, 1'b0);
        send(64'(N), 8, 1'b0, 1'b0);
        send(64'(N - 1), 8, 1'b1, 1'b0);
        send(64'hFFFF_FFFF_FFFF_FFFF, 64, 1'b0, 1'b0);
        send(64'h8000_0000_0000_0000, 64, 1'b1, 1'b0);
        idle_gap();
        idle_gap();

        // abandoned dividend, then restart via separate clear
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        exp_res = 0;
        chk("R1 clear before abort", int'(residue_o), 0);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b1, 1'b1, 1'b0);
            exp_res = ref_mod((64'd1 << (i + 1)) - 64'd1);
            chk("R4 partial", int'(residue_o), exp_res);
        end
        send(64'd12345, 16, 1'b0, 1'b1);
        // abandoned dividend, then merged restart over nonzero residue
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        exp_res = ref_mod(64'(2 * exp_res + 1));
        chk("R4 stray bit", int'(residue_o), exp_res);
        send(64'd0, 4, 1'b1, 1'b0);

        // constrained random dividends
        for (int k = 0; k < 400; k++) begin
            nb = 1 + int'($urandom % 64);
            v  = {$urandom, $urandom};
            if (nb < 64) v = v & ((64'd1 << nb) - 64'd1);
            send(v, nb, bit'($urandom % 2), bit'($urandom % 2));
            if ($urandom % 3 == 0) idle_gap();
        end

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule